// File: doc/BRIEF.md
# Push-Pull Steering Logic

This block turns a host-supplied clock pulse train into two alternating gate-drive enables for a push-pull power stage. It runs on a fast system clock and samples the host clock. Each high phase of the host clock sets one switching period. The length of that high phase is the longest on-time an output may have. Successive host periods are handed to the two outputs in turn, so each output switches at half the host clock rate.

An on-pulse starts when the host clock rises. It ends at the first of three events: the host clock falls, a PWM comparator trip arrives, or a current-limit trip arrives. A current-limit trip also raises a flag for the host. The flag stays set until the next host rising edge. An undervoltage-ok input gates everything. While it is low, both outputs stay off, the phase restarts on the first output, and the flag reads as not-ready.

The three asynchronous inputs pass through flop synchronizers. A programmable dead time keeps one output's turn-off well clear of the other's turn-on. The analog comparators, the slope ramp and the drivers lie outside the block.

Top module: `pp_steer`

## Requirements
- R1: While `uvOk` is low, and from reset, `drvA` and `drvB` are 0 and `limFlag` is 1. When `uvOk` returns, `limFlag` stays 1 until the next accepted host rising edge.
- R2: A rising edge on `hostClk` turns the selected output on at the third system clock edge after the input change. With no trip and the dead time satisfied, the output stays high for exactly as many system cycles as `hostClk` stayed high.
- R3: Accepted host periods go alternately to `drvA` and `drvB`. The first period after reset, or after `uvOk` returns, goes to `drvA`.
- R4: `pwmTrip` ends the running pulse three system edges after it rises. The output then stays low for the rest of that host period, even if `pwmTrip` falls again before `hostClk` does.
- R5: `curLim` high turns off any active output and sets `limFlag`, both three system edges after the input change.
- R6: `limFlag` holds at 1 until a host rising edge that arrives with `curLim` low. It is cleared three system edges after that edge. A host rising edge that arrives with `curLim` high leaves it at 1.
- R7: `drvA` and `drvB` are never high in the same cycle.
- R8: After an output turns off, neither output turns on for at least `DEAD_CYCLES` system cycles. A start that the dead time blocks is deferred within the same host high phase. The pulse still ends at the usual end event, so it is shortened by the deferral.
- R9: If `pwmTrip` or `curLim` is already high when the host rising edge is seen, that period gives no pulse. The alternation still advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `hostClk` |
| rstN | input | 1 | Asynchronous active-low reset |
| hostClk | input | 1 | Host pulse train: its period is the switching period, its high time is the maximum on-time |
| pwmTrip | input | 1 | PWM comparator trip, asynchronous, active high |
| curLim | input | 1 | Current-limit comparator trip, asynchronous, active high |
| uvOk | input | 1 | Supply-good level, synchronous to `clk`; low holds everything off |
| drvA | output | 1 | Gate enable of the first push-pull leg |
| drvB | output | 1 | Gate enable of the second push-pull leg |
| limFlag | output | 1 | Latched current-limit and not-ready flag for the host |

## Verification
Random host periods vary the high time, the low time and the point where a comparator trip or current limit lands. Comparing each logged pulse width and leg with the predicted one separates full-width pulses from trip-shortened ones, and shows the legs alternate correctly. Directed periods cover the edge cases one at a time:
- A trip that drops again before the host clock falls separates a true end-of-period hold from a restart.
- Trips already present at the rising edge separate skipped periods from a stalled alternation.
- A very short host low phase tells a deferred start apart from one that overlaps the dead time.
- Dropping `uvOk` in mid-pulse shows the immediate turn-off, the flag forced to not-ready, and the phase restarting on `drvA`.

// File: rtl/pp_steer_pkg.sv
package pp_steer_pkg;

  // Events seen by the control, all in the system clock domain
  typedef struct packed {
    logic rise;
    logic fall;
    logic trip;
    logic lim;
    logic deadBusy;
  } edgeInfo_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic startA;
    logic startB;
    logic stop;
    logic setFlag;
    logic clrFlag;
    logic clear;
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ON,
    ST_DONE
  } pulseState_t;

endpackage

// File: rtl/pp_steer_sync.sv
module pp_steer_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] shiftQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shiftQ <= '0;
      else       shiftQ <= {shiftQ[STAGES-2:0], din[b]};
    end
    assign dout[b] = shiftQ[STAGES-1];
  end

endmodule

// File: rtl/pp_steer_dp.sv
module pp_steer_dp
  import pp_steer_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEAD_CYCLES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      hostClk,
  input  logic      pwmTrip,
  input  logic      curLim,
  input  strobe_t   stb,
  output edgeInfo_t info,
  output logic      drvA,
  output logic      drvB,
  output logic      limFlag,
  output logic      hostRise,
  output logic      tripSync,
  output logic      limSync
);

  localparam int DW = $clog2(DEAD_CYCLES + 2);
  localparam logic [DW-1:0] DEAD_LOAD = DW'(DEAD_CYCLES);

  logic [2:0]    syncOut;
  logic          hostSync;
  logic          hostPrev;
  logic [DW-1:0] deadCnt;

  pp_steer_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({curLim, pwmTrip, hostClk}),
    .dout (syncOut)
  );

  assign hostSync = syncOut[0];
  assign tripSync = syncOut[1];
  assign limSync  = syncOut[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hostPrev <= 1'b0;
    else       hostPrev <= hostSync;
  end

  assign hostRise = hostSync & ~hostPrev;

  always_comb begin
    info          = '0;
    info.rise     = hostRise;
    info.fall     = ~hostSync & hostPrev;
    info.trip     = tripSync;
    info.lim      = limSync;
    info.deadBusy = (deadCnt != '0);
  end

  // Dead-time counter, loaded whenever a live pulse is stopped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                deadCnt <= '0;
    else if (stb.clear)       deadCnt <= '0;
    else if (stb.stop)        deadCnt <= DEAD_LOAD;
    else if (deadCnt != '0)   deadCnt <= deadCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drvA <= 1'b0;
      drvB <= 1'b0;
    end else if (stb.clear || stb.stop) begin
      drvA <= 1'b0;
      drvB <= 1'b0;
    end else begin
      if (stb.startA) drvA <= 1'b1;
      if (stb.startB) drvB <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         limFlag <= 1'b1;
    else if (stb.clear || stb.setFlag) limFlag <= 1'b1;
    else if (stb.clrFlag)              limFlag <= 1'b0;
  end

endmodule

// File: rtl/pp_steer_ctrl.sv
module pp_steer_ctrl
  import pp_steer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      uvOk,
  input  edgeInfo_t info,
  output strobe_t   stb
);

  pulseState_t state, stateNext;
  logic phase, phaseNext;   // leg for the next accepted period: 0 = A
  logic sel, selNext;       // leg owning the current period

  always_comb begin
    stb       = '0;
    stateNext = state;
    phaseNext = phase;
    selNext   = sel;
    if (!uvOk) begin
      stb.clear = 1'b1;
      stateNext = ST_IDLE;
      phaseNext = 1'b0;
      selNext   = 1'b0;
    end else begin
      if (info.lim)       stb.setFlag = 1'b1;
      else if (info.rise) stb.clrFlag = 1'b1;

      if (info.rise) begin
        selNext   = phase;
        phaseNext = ~phase;
        if (info.trip || info.lim) begin
          stateNext = ST_DONE;
        end else if (info.deadBusy) begin
          stateNext = ST_WAIT;
        end else begin
          stateNext  = ST_ON;
          stb.startA = ~phase;
          stb.startB = phase;
        end
      end else begin
        case (state)
          ST_WAIT: begin
            if (info.fall || info.trip || info.lim) begin
              stateNext = ST_DONE;
            end else if (!info.deadBusy) begin
              stateNext  = ST_ON;
              stb.startA = ~sel;
              stb.startB = sel;
            end
          end
          ST_ON: begin
            if (info.fall || info.trip || info.lim) begin
              stateNext = ST_DONE;
              stb.stop  = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= 1'b0;
      sel   <= 1'b0;
    end else begin
      state <= stateNext;
      phase <= phaseNext;
      sel   <= selNext;
    end
  end

endmodule

// File: rtl/pp_steer.sv
module pp_steer
  import pp_steer_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEAD_CYCLES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic hostClk,
  input  logic pwmTrip,
  input  logic curLim,
  input  logic uvOk,
  output logic drvA,
  output logic drvB,
  output logic limFlag
);

  edgeInfo_t info;
  strobe_t   stb;
  logic      hostRise;
  logic      tripSync;
  logic      limSync;

  pp_steer_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .uvOk (uvOk),
    .info (info),
    .stb  (stb)
  );

  pp_steer_dp #(.SYNC_STAGES(SYNC_STAGES), .DEAD_CYCLES(DEAD_CYCLES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .hostClk  (hostClk),
    .pwmTrip  (pwmTrip),
    .curLim   (curLim),
    .stb      (stb),
    .info     (info),
    .drvA     (drvA),
    .drvB     (drvB),
    .limFlag  (limFlag),
    .hostRise (hostRise),
    .tripSync (tripSync),
    .limSync  (limSync)
  );

endmodule

// File: rtl/pp_steer_chk.sv
module pp_steer_chk #(
  parameter int DEAD_CYCLES = 2
) (
  input logic clk,
  input logic rstN,
  input logic uvOk,
  input logic drvA,
  input logic drvB,
  input logic limFlag,
  input logic hostRise,
  input logic tripSync,
  input logic limSync
);

  localparam int GW = $clog2(DEAD_CYCLES + 2);
  localparam logic [GW-1:0] GAP_MAX = GW'(DEAD_CYCLES);

  // Cycles both legs have been low, saturating at the dead time
  logic [GW-1:0] gapCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               gapCnt <= GAP_MAX;
    else if (drvA || drvB)   gapCnt <= '0;
    else if (gapCnt < GAP_MAX) gapCnt <= gapCnt + 1'b1;
  end

  AST_UV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !uvOk |=> (!drvA && !drvB && limFlag));  // R1

  AST_TRIP_OFF: assert property (@(posedge clk) disable iff (!rstN)
    tripSync |=> (!drvA && !drvB));  // R4

  AST_LIM_OFF: assert property (@(posedge clk) disable iff (!rstN)
    limSync |=> (limFlag && !drvA && !drvB));  // R5

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (limFlag && !hostRise) |=> limFlag);  // R6

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(drvA && drvB));  // R7

  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(drvA) || $rose(drvB)) |-> (gapCnt >= GAP_MAX));  // R8

endmodule

bind pp_steer pp_steer_chk #(.DEAD_CYCLES(DEAD_CYCLES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .uvOk     (uvOk),
  .drvA     (drvA),
  .drvB     (drvB),
  .limFlag  (limFlag),
  .hostRise (hostRise),
  .tripSync (tripSync),
  .limSync  (limSync)
);

// File: tb/pp_steer_tb.sv
module pp_steer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEAD       = 2;
  localparam int NOTRIP     = 1000;
  localparam int LOGMAX     = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostClk = 1'b0;
  logic pwmTrip = 1'b0;
  logic curLim = 1'b0;
  logic uvOk = 1'b0;
  logic drvA, drvB, limFlag;

  pp_steer #(.SYNC_STAGES(2), .DEAD_CYCLES(DEAD)) u_dut (
    .clk(clk), .rstN(rstN), .hostClk(hostClk), .pwmTrip(pwmTrip),
    .curLim(curLim), .uvOk(uvOk), .drvA(drvA), .drvB(drvB), .limFlag(limFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pulse log built by the monitor: leg (0 = A) and width in samples
  int logLeg [LOGMAX];
  int logW   [LOGMAX];
  int logN = 0;
  int expLeg [LOGMAX];
  int expW   [LOGMAX];
  int expN = 0;
  int wA = 0, wB = 0, lowRun = 0, overlapSeen = 0, gapFails = 0;
  bit seenAny = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (drvA && drvB) overlapSeen++;
      if (!drvA && !drvB) lowRun++;
      else begin
        if (lowRun > 0 && seenAny && lowRun < DEAD) gapFails++;
        lowRun = 0;
        seenAny = 1'b1;
      end
      if (drvA) wA++;
      else if (wA > 0) begin
        if (logN < LOGMAX) begin logLeg[logN] = 0; logW[logN] = wA; end
        logN++; wA = 0;
      end
      if (drvB) wB++;
      else if (wB > 0) begin
        if (logN < LOGMAX) begin logLeg[logN] = 1; logW[logN] = wB; end
        logN++; wB = 0;
      end
    end
  end

  bit nextSel = 1'b0;
  bit flagHeld = 1'b1;

  function automatic int expWidth(int hi, int tripAt, int limAt, int defer);
    int m = hi;
    if (tripAt < m) m = tripAt;
    if (limAt < m) m = limAt;
    m = m - defer;
    return (m < 0) ? 0 : m;
  endfunction

  task automatic pushExp(input int leg, input int w);
    if (expN < LOGMAX) begin expLeg[expN] = leg; expW[expN] = w; end
    expN++;
  endtask

  // One host period; inputs change at negedges, outputs are sampled first
  task automatic runPeriod(input int hi, input int lo, input int tripAt,
                           input int tripLen, input int limAt, input int defer);
    int w = expWidth(hi, tripAt, limAt, defer);
    bit leg = nextSel;
    if (w > 0) pushExp(leg, w);
    nextSel = ~nextSel;
    for (int i = 0; i < hi + lo; i++) begin
      @(negedge clk);
      if (i == 2)
        check(limFlag == flagHeld, "R6 flag held before rise", limFlag, flagHeld);
      if (i == 2 && defer == 0 && w > 0)
        check((leg ? drvB : drvA) == 1'b0, "R2 not yet on at edge 2", leg ? drvB : drvA, 0);
      if (i == 3)
        check(limFlag == (limAt == 0), "R6 flag after rise", limFlag, limAt == 0);
      if (i == 3 && defer == 0 && w > 0)
        check((leg ? drvB : drvA) == 1'b1, "R2 on at edge 3", leg ? drvB : drvA, 1);
      if (i == hi + lo - 1 && limAt < hi + lo)
        check(limFlag == 1'b1, "R5 flag set by limit", limFlag, 1);
      hostClk = (i < hi);
      pwmTrip = (i >= tripAt) && (i < tripAt + tripLen);
      curLim  = (i >= limAt);
    end
    flagHeld = (limAt < hi + lo);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hostClk = 1'b0; pwmTrip = 1'b0; curLim = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'h1234_abcd));
    repeat (3) @(negedge clk);
    check(drvA == 0 && drvB == 0, "R1 reset outputs low", {drvA, drvB}, 0);
    check(limFlag == 1, "R1 reset flag high", limFlag, 1);
    rstN = 1'b1;
    @(negedge clk);
    uvOk = 1'b1;
    idle(4);

    // R2, R3: plain periods, alternation starting on A
    runPeriod(6, 5, NOTRIP, 0, NOTRIP, 0);
    runPeriod(4, 4, NOTRIP, 0, NOTRIP, 0);
    runPeriod(9, 3, NOTRIP, 0, NOTRIP, 0);
    // R4: trip that drops before the host clock falls, no restart
    runPeriod(10, 4, 3, 2, NOTRIP, 0);
    // R5: current limit mid pulse, R6 cleared next period
    runPeriod(8, 4, NOTRIP, 0, 4, 0);
    runPeriod(5, 4, NOTRIP, 0, NOTRIP, 0);
    // R9: trip or limit present at the rise: skipped period, phase advances
    runPeriod(6, 4, 0, 99, NOTRIP, 0);
    runPeriod(6, 4, NOTRIP, 0, 0, 0);
    runPeriod(6, 4, NOTRIP, 0, NOTRIP, 0);
    // R8: short low phase, next start deferred by DEAD+1-lo cycles
    runPeriod(6, 4, NOTRIP, 0, NOTRIP, 0);
    runPeriod(6, 1, NOTRIP, 0, NOTRIP, 0);
    runPeriod(6, 5, NOTRIP, 0, NOTRIP, DEAD);
    runPeriod(5, 4, NOTRIP, 0, NOTRIP, 0);

    // Random periods with trips and limits landing at random offsets
    for (int k = 0; k < 40; k++) begin
      int hi = 2 + int'($urandom % 11);
      int lo = 3 + int'($urandom % 6);
      int tripAt = NOTRIP;
      int tripLen = 0;
      int limAt = NOTRIP;
      if ($urandom % 4 == 0) begin
        tripAt = 1 + int'($urandom % hi);
        tripLen = 1 + int'($urandom % 12);
      end
      if ($urandom % 8 == 0) limAt = 1 + int'($urandom % hi);
      runPeriod(hi, lo, tripAt, tripLen, limAt, 0);
    end

    // R1, R3: supply drop in mid pulse, phase restarts on A
    runPeriod(5, 4, NOTRIP, 0, NOTRIP, 0);
    pushExp(nextSel, 3);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i == 6) begin
        check(drvA == 0 && drvB == 0, "R1 outputs off on supply drop", {drvA, drvB}, 0);
        check(limFlag == 1, "R1 flag not-ready on supply drop", limFlag, 1);
      end
      hostClk = (i < 8);
      if (i == 5) uvOk = 1'b0;
    end
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        hostClk = (i < 5);
      end
    end
    @(negedge clk);
    check(drvA == 0 && drvB == 0, "R1 outputs stay off", {drvA, drvB}, 0);
    hostClk = 1'b0;
    uvOk = 1'b1;
    idle(4);
    check(limFlag == 1, "R1 flag held after supply return", limFlag, 1);
    nextSel = 1'b0;
    flagHeld = 1'b1;
    runPeriod(6, 4, NOTRIP, 0, NOTRIP, 0);
    runPeriod(6, 4, NOTRIP, 0, NOTRIP, 0);
    idle(12);

    // Compare pulse log against prediction (R2, R3, R4, R5, R8)
    check(logN == expN, "R3 pulse count", logN, expN);
    for (int i = 0; i < expN && i < logN && i < LOGMAX; i++) begin
      check(logLeg[i] == expLeg[i], "R3 pulse leg", logLeg[i], expLeg[i]);
      check(logW[i] == expW[i], "R2 R4 R5 R8 pulse width", logW[i], expW[i]);
    end
    check(overlapSeen == 0, "R7 legs overlapped", overlapSeen, 0);
    check(gapFails == 0, "R8 dead gap too short", gapFails, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all) actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule